// File: doc/BRIEF.md
# Control Endpoint Stage Controller

This block follows the three stages of a full-speed control transfer on endpoint 0 from the device side. It takes already decoded token events from the serial engine and the eight setup bytes that arrive with a SETUP token. From these it picks the handshake for each transaction (ACK, NACK or STALL) and keeps a data-direction flag and a "service data" flag for the CPU. It also raises two sticky interrupt flags. The CPU steers the transfer with single-cycle command strobes: clear service data, predict a read, data loaded, enable status, and stall.

Configuration and interface selection, plus clearing of endpoint halt and remote wake-up, are done by the block itself. The CPU reads the active configuration, interface and alternate setting from output ports. Every other request is handed to the CPU through the setup interrupt. Serialisation, CRC, line coding, the data FIFO and descriptor storage are outside this block. A handshake appears on `hs_o` one clock after its token and lasts one cycle. In every other cycle `hs_o` reads NONE.

Top module: `ep0_ctrl_stage`

## Requirements
- R1: A SETUP token (`tok_kind_i`=0) is always answered ACK (`hs_o`=1) on the next cycle. It clears stall, service data and the loaded state, and sets the direction to write (`dir_o`=0). It enters the status stage when wLength (setup bytes 7:6) is zero and the data stage otherwise. It aborts any stage in progress.
- R2: In the data stage with direction write, an OUT (`tok_kind_i`=1) is ACKed and sets `sod_o` when `sod_o` is clear. While `sod_o` is set the OUT is NACKed (`hs_o`=2). A `cpu_sod_clr_i` strobe clears `sod_o`.
- R3: An IN (`tok_kind_i`=2) that arrives in the data stage while the direction is write and no OUT has yet been accepted is NACKed. It sets `dir_o` to 1 and sets `sod_o`.
- R4: `cpu_set_rd_i` during the data stage sets `dir_o` to 1 and sets `sod_o` unless data is already loaded. After a `cpu_in_rdy_i`, the first IN is ACKed with no NACK.
- R5: With direction read, a data-stage IN is ACKed only when data is loaded. The ACK consumes the load and sets `sod_o` again. Otherwise the IN is NACKed. `cpu_in_rdy_i` marks data loaded and clears `sod_o`.
- R6: A status-stage token is any token once the status stage is entered. In the data stage it is an OUT when reading, or an IN after an accepted OUT when writing. It is ACKed only while `status_en_o` is set. The ACK ends the transfer and clears `status_en_o` and `sod_o`.
- R7: A status-stage token that arrives while `status_en_o` is clear is NACKed and sets interrupt flag bit 1 (`irq_flags_o[1]`).
- R8: After `cpu_stall_i`, every IN or OUT is answered STALL (`hs_o`=3) until the next SETUP.
- R9: Set_Configuration (request type 0x00, request 9) loads `cfg_o` from wValue and zeroes `intf_o` and `alt_o`. Set_Interface (type 0x01, request 11) loads `intf_o` from wIndex and `alt_o` from wValue. Both set `status_en_o` at once and raise no interrupt.
- R10: Clear_Feature (request 1) with type 0x02 and feature 0 clears `ep_halt_o` bit wIndex[3:0] when that index is below NUM_EP. With type 0x00 and feature 1 it clears `rwu_o`. Both are handled by the block like R9. A Clear_Feature for an endpoint at or above NUM_EP goes to the CPU.
- R11: Every other request, for example Get_Descriptor (6), Set_Descriptor (7) or Synch_Frame (12), sets interrupt flag bit 0 and leaves `status_en_o` clear.
- R12: Interrupt flags are sticky. A one in `cpu_irq_clr_i` clears the matching flag, and a set in the same cycle wins. `irq_o` is the OR of the flags.
- R13: After reset every output is zero. An IN or OUT with no transfer open is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token event valid |
| tok_kind_i | input | 2 | 0 SETUP, 1 OUT, 2 IN, 3 none |
| setup_data_i | input | 64 | Setup bytes, byte 0 in bits 7:0 |
| cpu_sod_clr_i | input | 1 | CPU has read OUT data |
| cpu_set_rd_i | input | 1 | Predict read direction |
| cpu_in_rdy_i | input | 1 | IN data loaded |
| cpu_status_en_i | input | 1 | Allow status stage ACK |
| cpu_stall_i | input | 1 | Stall the current transfer |
| cpu_halt_set_i | input | NUM_EP | Set endpoint halt bits |
| cpu_rwu_set_i | input | 1 | Set remote wake-up enable |
| cpu_irq_clr_i | input | 2 | Write-one-to-clear of flags |
| hs_o | output | 2 | 0 none, 1 ACK, 2 NACK, 3 STALL |
| dir_o | output | 1 | 1 = device to host |
| sod_o | output | 1 | CPU service needed |
| status_en_o | output | 1 | Status stage enabled |
| stall_o | output | 1 | Transfer stalled |
| irq_flags_o | output | 2 | Bit 0 setup, bit 1 early status |
| irq_o | output | 1 | Interrupt request |
| cfg_o | output | CFG_W | Active configuration |
| intf_o | output | CFG_W | Active interface |
| alt_o | output | CFG_W | Active alternate setting |
| ep_halt_o | output | NUM_EP | Endpoint halt bits |
| rwu_o | output | 1 | Remote wake-up enable |

## Verification
A wrong direction or loaded state shows up on the very next IN. The reply turns into an ACK where a NACK is due, or the reverse, and `dir_o` or `sod_o` disagrees one cycle after the token. A lost status enable or stall shows as a wrong handshake on the first status or data token. A bad decode of a request shows at once on `cfg_o`, `ep_halt_o`, `rwu_o`, `status_en_o` or the setup flag in the cycle after the SETUP. The bench compares every output against a behavioural model on every clock, so a fault is reported in the cycle it reaches a port.

// File: rtl/ep0_pkg.sv
package ep0_pkg;
  typedef enum logic [1:0] {TK_SETUP = 2'd0, TK_OUT = 2'd1, TK_IN = 2'd2, TK_NONE = 2'd3} tok_e;
  typedef enum logic [1:0] {HS_NONE = 2'd0, HS_ACK = 2'd1, HS_NACK = 2'd2, HS_STALL = 2'd3} hs_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_DATA = 2'd1, ST_STATUS = 2'd2} stage_e;

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] idx;
    logic [15:0] val;
    logic [7:0]  req;
    logic [7:0]  rtype;
  } setup_t;

  localparam logic [7:0]  RQ_CLR_FEATURE = 8'd1;
  localparam logic [7:0]  RQ_SET_CONFIG  = 8'd9;
  localparam logic [7:0]  RQ_SET_IFACE   = 8'd11;
  localparam logic [7:0]  RT_DEV_OUT     = 8'h00;
  localparam logic [7:0]  RT_IF_OUT      = 8'h01;
  localparam logic [7:0]  RT_EP_OUT      = 8'h02;
  localparam logic [15:0] FEAT_EP_HALT   = 16'd0;
  localparam logic [15:0] FEAT_RWAKE     = 16'd1;

  localparam int IRQ_SETUP  = 0;
  localparam int IRQ_STATUS = 1;
  localparam int NUM_IRQ    = 2;
endpackage

// File: rtl/ep0_std_req.sv
module ep0_std_req
  import ep0_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CFG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  setup_t            setup_i,
  input  logic [NUM_EP-1:0] cpu_halt_set_i,
  input  logic              cpu_rwu_set_i,
  output logic              hw_req_o,
  output logic              no_data_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CFG_W-1:0]  intf_o,
  output logic [CFG_W-1:0]  alt_o,
  output logic [NUM_EP-1:0] ep_halt_o,
  output logic              rwu_o
);
  localparam logic [4:0] EP_LIM = 5'(NUM_EP);

  logic set_cfg, set_if, clr_halt, clr_rwu;
  logic unused_idx_hi;

  assign unused_idx_hi = ^setup_i.idx[15:4];

  assign set_cfg  = setup_i.rtype == RT_DEV_OUT && setup_i.req == RQ_SET_CONFIG;
  assign set_if   = setup_i.rtype == RT_IF_OUT  && setup_i.req == RQ_SET_IFACE;
  assign clr_rwu  = setup_i.rtype == RT_DEV_OUT && setup_i.req == RQ_CLR_FEATURE
                    && setup_i.val == FEAT_RWAKE;
  assign clr_halt = setup_i.rtype == RT_EP_OUT && setup_i.req == RQ_CLR_FEATURE
                    && setup_i.val == FEAT_EP_HALT && ({1'b0, setup_i.idx[3:0]} < EP_LIM);

  assign hw_req_o  = set_cfg | set_if | clr_rwu | clr_halt;
  assign no_data_o = setup_i.len == 16'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o  <= '0;
      intf_o <= '0;
      alt_o  <= '0;
    end else if (fire_i && set_cfg) begin
      cfg_o  <= setup_i.val[CFG_W-1:0];
      intf_o <= '0;
      alt_o  <= '0;
    end else if (fire_i && set_if) begin
      intf_o <= setup_i.idx[CFG_W-1:0];
      alt_o  <= setup_i.val[CFG_W-1:0];
    end
  end

  for (genvar i = 0; i < NUM_EP; i++) begin : g_halt
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                          ep_halt_o[i] <= 1'b0;
      else if (fire_i && clr_halt && setup_i.idx[3:0] == 4'(i)) ep_halt_o[i] <= 1'b0;
      else if (cpu_halt_set_i[i])                           ep_halt_o[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rwu_o <= 1'b0;
    else if (fire_i && clr_rwu)   rwu_o <= 1'b0;
    else if (cpu_rwu_set_i)       rwu_o <= 1'b1;
  end

  p_cfg_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && set_cfg |=> cfg_o == $past(setup_i.val[CFG_W-1:0]) && intf_o == '0 && alt_o == '0);
  p_rwu_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i && clr_rwu |=> !rwu_o);
endmodule

// File: rtl/ep0_irq_flags.sv
module ep0_irq_flags #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o,
  output logic         irq_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flags_o[i] <= 1'b0;
      else if (set_i[i]) flags_o[i] <= 1'b1;
      else if (clr_i[i]) flags_o[i] <= 1'b0;
    end

    p_sticky_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flags_o[i] && !clr_i[i] |=> flags_o[i]);
  end

  assign irq_o = |flags_o;
endmodule

// File: rtl/ep0_stage_fsm.sv
module ep0_stage_fsm
  import ep0_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tok_valid_i,
  input  tok_e tok_kind_i,
  input  logic no_data_i,
  input  logic hw_req_i,
  input  logic cpu_sod_clr_i,
  input  logic cpu_set_rd_i,
  input  logic cpu_in_rdy_i,
  input  logic cpu_status_en_i,
  input  logic cpu_stall_i,
  output hs_e  hs_o,
  output logic dir_o,
  output logic sod_o,
  output logic status_en_o,
  output logic stall_o,
  output logic early_status_o
);
  stage_e stage_q, stage_n;
  hs_e    hs_n;
  logic   dir_n, sod_n, en_n, stall_n;
  logic   loaded_q, loaded_n, seen_q, seen_n;
  logic   is_in, status_tok, setup_now, data_tok;

  assign is_in      = tok_kind_i == TK_IN;
  assign setup_now  = tok_valid_i && tok_kind_i == TK_SETUP;
  assign data_tok   = tok_valid_i && (tok_kind_i == TK_IN || tok_kind_i == TK_OUT);
  // status token: opposite of the data direction, or anything once in status
  assign status_tok = stage_q == ST_STATUS || (dir_o ? !is_in : (is_in && seen_q));

  always_comb begin
    stage_n = stage_q;  dir_n  = dir_o;   sod_n    = sod_o;
    en_n    = status_en_o; stall_n = stall_o; loaded_n = loaded_q;
    seen_n  = seen_q;   hs_n   = HS_NONE; early_status_o = 1'b0;
    if (setup_now) begin
      hs_n     = HS_ACK;
      stage_n  = no_data_i ? ST_STATUS : ST_DATA;
      dir_n    = 1'b0;
      sod_n    = 1'b0;
      en_n     = hw_req_i;
      stall_n  = 1'b0;
      loaded_n = 1'b0;
      seen_n   = 1'b0;
    end else if (data_tok) begin
      if (stall_o) begin
        hs_n = HS_STALL;
      end else if (stage_q == ST_IDLE) begin
        hs_n = HS_NACK;
      end else if (status_tok) begin
        if (status_en_o) begin
          hs_n    = HS_ACK;
          stage_n = ST_IDLE;
          en_n    = 1'b0;
          sod_n   = 1'b0;
        end else begin
          hs_n    = HS_NACK;
          stage_n = ST_STATUS;
          early_status_o = 1'b1;
        end
      end else if (!dir_o) begin
        if (is_in) begin
          hs_n  = HS_NACK;
          dir_n = 1'b1;
          sod_n = 1'b1;
        end else if (sod_o) begin
          hs_n = HS_NACK;
        end else begin
          hs_n   = HS_ACK;
          sod_n  = 1'b1;
          seen_n = 1'b1;
        end
      end else if (loaded_q) begin
        hs_n     = HS_ACK;
        loaded_n = 1'b0;
        sod_n    = 1'b1;
        seen_n   = 1'b1;
      end else begin
        hs_n = HS_NACK;
      end
    end
    if (!setup_now) begin
      if (cpu_sod_clr_i) sod_n = 1'b0;
      if (cpu_set_rd_i && stage_q == ST_DATA) begin
        dir_n = 1'b1;
        if (!loaded_n) sod_n = 1'b1;
      end
      if (cpu_in_rdy_i) begin
        loaded_n = 1'b1;
        sod_n    = 1'b0;
      end
      if (cpu_status_en_i) en_n = 1'b1;
      if (cpu_stall_i) stall_n = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= ST_IDLE; hs_o <= HS_NONE; dir_o <= 1'b0; sod_o <= 1'b0;
      status_en_o <= 1'b0; stall_o <= 1'b0; loaded_q <= 1'b0; seen_q <= 1'b0;
    end else begin
      stage_q <= stage_n; hs_o <= hs_n; dir_o <= dir_n; sod_o <= sod_n;
      status_en_o <= en_n; stall_o <= stall_n; loaded_q <= loaded_n; seen_q <= seen_n;
    end
  end

  p_setup_init_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    setup_now |=> hs_o == HS_ACK && !dir_o && !stall_o && !sod_o);
  p_out_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_tok && !is_in && stage_q == ST_DATA && !dir_o && sod_o && !stall_o |=> hs_o == HS_NACK);
  p_first_in_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_tok && is_in && stage_q == ST_DATA && !dir_o && !seen_q && !stall_o
    |=> hs_o == HS_NACK && dir_o);
  p_status_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_tok && stage_q == ST_STATUS && status_en_o && !stall_o && !cpu_status_en_i
    |=> hs_o == HS_ACK && !status_en_o && !sod_o);
  p_stall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_tok && stall_o |=> hs_o == HS_STALL);
endmodule

// File: rtl/ep0_ctrl_stage.sv
module ep0_ctrl_stage
  import ep0_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int CFG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tok_valid_i,
  input  logic [1:0]        tok_kind_i,
  input  logic [63:0]       setup_data_i,
  input  logic              cpu_sod_clr_i,
  input  logic              cpu_set_rd_i,
  input  logic              cpu_in_rdy_i,
  input  logic              cpu_status_en_i,
  input  logic              cpu_stall_i,
  input  logic [NUM_EP-1:0] cpu_halt_set_i,
  input  logic              cpu_rwu_set_i,
  input  logic [1:0]        cpu_irq_clr_i,
  output logic [1:0]        hs_o,
  output logic              dir_o,
  output logic              sod_o,
  output logic              status_en_o,
  output logic              stall_o,
  output logic [1:0]        irq_flags_o,
  output logic              irq_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic [CFG_W-1:0]  intf_o,
  output logic [CFG_W-1:0]  alt_o,
  output logic [NUM_EP-1:0] ep_halt_o,
  output logic              rwu_o
);
  setup_t               su;
  tok_e                 kind;
  hs_e                  hs;
  logic                 fire, hw_req, no_data, early;
  logic [NUM_IRQ-1:0]   irq_set;

  assign su   = setup_t'(setup_data_i);
  assign kind = tok_e'(tok_kind_i);
  assign fire = tok_valid_i && kind == TK_SETUP;

  ep0_std_req #(.NUM_EP(NUM_EP), .CFG_W(CFG_W)) u_req (
    .clk_i, .rst_ni, .fire_i(fire), .setup_i(su),
    .cpu_halt_set_i, .cpu_rwu_set_i,
    .hw_req_o(hw_req), .no_data_o(no_data),
    .cfg_o, .intf_o, .alt_o, .ep_halt_o, .rwu_o
  );

  ep0_stage_fsm u_fsm (
    .clk_i, .rst_ni, .tok_valid_i, .tok_kind_i(kind),
    .no_data_i(no_data), .hw_req_i(hw_req),
    .cpu_sod_clr_i, .cpu_set_rd_i, .cpu_in_rdy_i, .cpu_status_en_i, .cpu_stall_i,
    .hs_o(hs), .dir_o, .sod_o, .status_en_o, .stall_o, .early_status_o(early)
  );

  assign hs_o = hs;

  always_comb begin
    irq_set             = '0;
    irq_set[IRQ_SETUP]  = fire && !hw_req;
    irq_set[IRQ_STATUS] = early;
  end

  ep0_irq_flags #(.N(NUM_IRQ)) u_irq (
    .clk_i, .rst_ni, .set_i(irq_set), .clr_i(cpu_irq_clr_i),
    .flags_o(irq_flags_o), .irq_o
  );

  p_early_irq_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    early |=> irq_flags_o[IRQ_STATUS] && hs_o == 2'd2);
  p_cpu_req_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !hw_req |=> irq_flags_o[IRQ_SETUP] && !status_en_o);
endmodule

// File: tb/tb_ep0_ctrl_stage.sv
module tb_ep0_ctrl_stage;
  localparam int CLK_PERIOD = 10;
  localparam int NEP = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tok_valid = 0; logic [1:0] tok_kind = 2'd3; logic [63:0] setup_data = '0;
  logic sod_clr = 0, set_rd = 0, in_rdy = 0, st_en = 0, stall_c = 0, rwu_set = 0;
  logic [NEP-1:0] halt_set = '0; logic [1:0] irq_clr = '0;

  logic [1:0] hs_o, irq_flags_o; logic dir_o, sod_o, status_en_o, stall_o, irq_o, rwu_o;
  logic [7:0] cfg_o, intf_o, alt_o; logic [NEP-1:0] ep_halt_o;

  ep0_ctrl_stage dut (
    .clk_i(clk), .rst_ni(rst_n), .tok_valid_i(tok_valid), .tok_kind_i(tok_kind),
    .setup_data_i(setup_data), .cpu_sod_clr_i(sod_clr), .cpu_set_rd_i(set_rd),
    .cpu_in_rdy_i(in_rdy), .cpu_status_en_i(st_en), .cpu_stall_i(stall_c),
    .cpu_halt_set_i(halt_set), .cpu_rwu_set_i(rwu_set), .cpu_irq_clr_i(irq_clr),
    .hs_o, .dir_o, .sod_o, .status_en_o, .stall_o, .irq_flags_o, .irq_o,
    .cfg_o, .intf_o, .alt_o, .ep_halt_o, .rwu_o
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0; bit done = 0;
  string cur_req = "R13";

  // reference model state (stage: 0 idle, 1 data, 2 status)
  int m_stage, m_hs; bit m_dir, m_sod, m_en, m_stall, m_loaded, m_seen, m_rwu;
  bit [1:0] m_irq; int m_cfg, m_intf, m_alt; bit [NEP-1:0] m_halt;

  task automatic model_reset();
    m_stage = 0; m_hs = 0; m_dir = 0; m_sod = 0; m_en = 0; m_stall = 0; m_loaded = 0;
    m_seen = 0; m_rwu = 0; m_irq = 0; m_cfg = 0; m_intf = 0; m_alt = 0; m_halt = 0;
  endtask

  task automatic model_step();
    int nhs = 0; bit early = 0, sirq = 0, is_setup, isin, stat;
    int rt, rq, val, idx, len; bit hw, c_cfg, c_if, c_rwu, c_halt;
    m_halt = m_halt | halt_set;
    if (rwu_set) m_rwu = 1;
    is_setup = tok_valid && tok_kind == 2'd0;
    if (is_setup) begin
      rt = int'(setup_data[7:0]); rq = int'(setup_data[15:8]);
      val = int'(setup_data[31:16]); idx = int'(setup_data[47:32]); len = int'(setup_data[63:48]);
      c_cfg  = rt == 0 && rq == 9;
      c_if   = rt == 1 && rq == 11;
      c_rwu  = rt == 0 && rq == 1 && val == 1;
      c_halt = rt == 2 && rq == 1 && val == 0 && (idx % 16) < NEP;
      hw = c_cfg || c_if || c_rwu || c_halt;
      if (c_cfg) begin m_cfg = val % 256; m_intf = 0; m_alt = 0; end
      if (c_if) begin m_intf = idx % 256; m_alt = val % 256; end
      if (c_rwu) m_rwu = 0;
      if (c_halt) m_halt[idx % 16] = 0;
      nhs = 1; m_stage = (len == 0) ? 2 : 1;
      m_dir = 0; m_sod = 0; m_en = hw; m_stall = 0; m_loaded = 0; m_seen = 0;
      sirq = !hw;
    end else if (tok_valid && (tok_kind == 2'd1 || tok_kind == 2'd2)) begin
      isin = tok_kind == 2'd2;
      stat = (m_stage == 2) || (m_dir ? !isin : (isin && m_seen));
      if (m_stall) nhs = 3;
      else if (m_stage == 0) nhs = 2;
      else if (stat) begin
        if (m_en) begin nhs = 1; m_stage = 0; m_en = 0; m_sod = 0; end
        else begin nhs = 2; m_stage = 2; early = 1; end
      end else if (!m_dir) begin
        if (isin) begin nhs = 2; m_dir = 1; m_sod = 1; end
        else if (m_sod) nhs = 2;
        else begin nhs = 1; m_sod = 1; m_seen = 1; end
      end else if (m_loaded) begin nhs = 1; m_loaded = 0; m_sod = 1; m_seen = 1; end
      else nhs = 2;
    end
    if (!is_setup) begin
      // apply CPU commands; set_rd acts only while a data stage is open
      if (sod_clr) m_sod = 0;
      if (set_rd && m_stage_before_is_data) begin m_dir = 1; if (!m_loaded) m_sod = 1; end
      if (in_rdy) begin m_loaded = 1; m_sod = 0; end
      if (st_en) m_en = 1;
      if (stall_c) m_stall = 1;
    end
    m_irq[0] = sirq || (m_irq[0] && !irq_clr[0]);
    m_irq[1] = early || (m_irq[1] && !irq_clr[1]);
    m_hs = nhs;
  endtask

  bit m_stage_before_is_data;

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("hs", int'(hs_o), m_hs);
    chk("dir", int'(dir_o), int'(m_dir));
    chk("sod", int'(sod_o), int'(m_sod));
    chk("status_en", int'(status_en_o), int'(m_en));
    chk("stall", int'(stall_o), int'(m_stall));
    chk("irq_flags", int'(irq_flags_o), int'(m_irq));
    chk("irq", int'(irq_o), int'(|m_irq));
    chk("cfg", int'(cfg_o), m_cfg);
    chk("intf", int'(intf_o), m_intf);
    chk("alt", int'(alt_o), m_alt);
    chk("ep_halt", int'(ep_halt_o), int'(m_halt));
    chk("rwu", int'(rwu_o), int'(m_rwu));
  endtask

  task automatic cyc();
    m_stage_before_is_data = (m_stage == 1);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    tok_valid = 0; tok_kind = 2'd3; sod_clr = 0; set_rd = 0; in_rdy = 0; st_en = 0;
    stall_c = 0; rwu_set = 0; halt_set = '0; irq_clr = '0;
  endtask

  task automatic tok(input logic [1:0] k);
    tok_valid = 1; tok_kind = k; cyc(); cyc();
  endtask

  task automatic setup(input int rt, input int rq, input int val, input int idx, input int len);
    setup_data = {16'(len), 16'(idx), 16'(val), 8'(rq), 8'(rt)};
    tok(2'd0);
  endtask

  task automatic cpu(input int which);
    case (which)
      0: sod_clr = 1; 1: set_rd = 1; 2: in_rdy = 1; 3: st_en = 1; default: stall_c = 1;
    endcase
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    cur_req = "R13"; compare_all();          // R13 reset state
    tok(2'd2);                               // R13 IN with no transfer open
    // control write: R11 setup irq, R2 OUT flow, R7 early status, R12 clear, R6 status ACK
    cur_req = "R11"; setup(8'h40, 5, 0, 0, 8);
    cur_req = "R2";  tok(2'd1); tok(2'd1); cpu(0); tok(2'd1); cpu(0);
    cur_req = "R7";  tok(2'd2);
    cur_req = "R12"; irq_clr = 2'b01; cyc(); irq_clr = 2'b10; cyc();
    cur_req = "R6";  cpu(3); tok(2'd2); tok(2'd2);
    // control read without prediction: R3 then R5, status by OUT
    cur_req = "R11"; setup(8'h80, 6, 16'h0100, 0, 18);
    cur_req = "R3";  tok(2'd2);
    cur_req = "R5";  cpu(2); tok(2'd2); tok(2'd2); cpu(2); tok(2'd2);
    cur_req = "R7";  tok(2'd1);
    cur_req = "R6";  cpu(3); tok(2'd1);
    // predicted read: R4
    cur_req = "R4";  setup(8'h80, 6, 16'h0200, 0, 64); cpu(1); cpu(2); tok(2'd2);
    // stall: R8, then R1 clears it
    cur_req = "R8";  setup(8'h82, 12, 0, 1, 2); cpu(4); tok(2'd2); tok(2'd1); cpu(3); tok(2'd1);
    cur_req = "R1";  setup(8'h80, 7, 0, 0, 0);
    cur_req = "R1";  setup(8'h80, 6, 0, 0, 9); tok(2'd2); setup(8'h00, 5, 0, 0, 4);
    // R9 configuration and interface
    cur_req = "R9";  setup(8'h01, 11, 2, 1, 0); tok(2'd2);
    setup(8'h00, 9, 3, 0, 0); tok(2'd2);
    // R10 clear feature
    cur_req = "R10"; halt_set = 4'b1111; rwu_set = 1; cyc();
    setup(8'h02, 1, 0, 8'h82, 0); tok(2'd2);
    setup(8'h02, 1, 0, 5, 0);
    setup(8'h00, 1, 1, 0, 0); tok(2'd2);
    // R12 set beats clear in the same cycle
    cur_req = "R12"; setup(8'h80, 6, 0, 0, 4); tok(2'd1);
    irq_clr = 2'b11; setup_data = 64'h0004_0000_0000_0680; tok_valid = 1; tok_kind = 2'd0; cyc(); cyc();
    repeat (3) cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule